// File: doc/BRIEF.md
# Address-Data SPI Register Bridge

This block connects an 8-bit SPI slave (mode 0: the master drives and the slave shifts on the falling clock edge, both sides sample on the rising edge, most significant bit first) to a small map of 16-bit registers. The master uses two active-low select lines. A frame opened with the address select carries exactly one address byte. A frame opened with the data select carries any number of data bytes. All SPI lines are oversampled by the system clock. The SPI clock half-period must therefore be at least five system clock cycles.

The address byte picks the direction and the target. The captured address stays in force until the next address frame, so one address phase can be followed by any number of data words. Each pair of data bytes forms one 16-bit word, low byte first. The byte pairing restarts only at an address byte, so a word may span two data frames.

Inside, a uniform backend strobe interface (address, write data, read data, write strobe, read strobe) reaches the register map. The map holds three operands, a registered sum, a first-word-fall-through FIFO port, RAM address registers, a RAM data port and an enable bit. Read data is combinational, so the next byte to send is always ready before its first clock edge.

Top module: `spi_regbridge`

## Requirements
- R1: An address byte with bit 7 = 0 selects write, and with bit 7 = 1 selects read. Bits 6:0 give the register number. The direction and register stay in force for every following data frame until the next address byte. MISO is 0 throughout an address frame.
- R2: Data bytes pair up into 16-bit words, first byte = bits 7:0 and second byte = bits 15:8. A write takes effect only after the second byte of a word. Read words are returned in the same byte order.
- R3: Registers 1, 2 and 3 are 16-bit read/write operands that reset to 0.
- R4: Register 0 is read-only and resets to 0. While enabled, it follows (reg1 + reg2 + reg3) mod 65536, one clock behind the operands. While disabled, it holds its value.
- R5: Register 4 is a FIFO port with a default depth of 256. A write word pushes. A read word returns the oldest entry and pops it after the word's second byte. Several words can be pushed or popped after a single address byte, in first-in first-out order.
- R6: A push into a full FIFO is dropped. A read from an empty FIFO returns 0 and pops nothing.
- R7: A write to register 5 sets the RAM write address and a write to register 6 sets the RAM read address (the low 8 bits of the word in each case). Writing register 7 stores the word at the write address. Reading register 7 returns the word at the read address.
- R8: Register 8 bit 0 is the enable. It resets to 0 and reads back as {15'b0, enable}.
- R9: While the enable is 0, FIFO pushes, FIFO pops and RAM stores are ignored, and reads of registers 4 and 7 return 0.
- R10: Reads of registers 5, 6 and 9 to 127 return 0. Writes to registers 0 and 9 to 127 change nothing.
- R11: For a read, the slave presents each byte's bit 7 on MISO before the byte's first rising SCLK edge. It shifts the remaining bits out on the falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_sel_addr_n | input | 1 | Active-low select for address frames |
| spi_sel_data_n | input | 1 | Active-low select for data frames |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data |

## Verification
The hardest conditions to reach are the FIFO edges: a push dropped on a full queue, and a pop refused on an empty one. The bench reaches both with a reduced FIFO depth of 8. It streams ten words in one data frame after a single address byte, then drains nine words in one data frame, so the overflow drop and the empty-read zero show up in a single run. The same long-frame path checks that the address and byte pairing persist across many words. The enable-off cases are reached by clearing the enable bit between filled RAM and FIFO accesses, then re-enabling and reading back the untouched contents.

// File: rtl/spirb_pkg.sv
// Shared constants for the SPI register bridge: data widths and the register numbers.
package spirb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] RG_SUM   = 7'd0;
    localparam logic [ADDR_W-1:0] RG_OPA   = 7'd1;
    localparam logic [ADDR_W-1:0] RG_OPB   = 7'd2;
    localparam logic [ADDR_W-1:0] RG_OPC   = 7'd3;
    localparam logic [ADDR_W-1:0] RG_FIFO  = 7'd4;
    localparam logic [ADDR_W-1:0] RG_RWADR = 7'd5;
    localparam logic [ADDR_W-1:0] RG_RRADR = 7'd6;
    localparam logic [ADDR_W-1:0] RG_RDATA = 7'd7;
    localparam logic [ADDR_W-1:0] RG_CTRL  = 7'd8;
endpackage

// File: rtl/spirb_shifter.sv
// Byte-level SPI mode-0 slave, oversampled by clk.
// Assumes the SCLK half-period is at least five clk cycles and SCLK idles low.
// Emits one byte_done pulse per received byte, tagged with the frame type.
// Loads tx_byte at frame start and after every completed byte.
module spirb_shifter
    import spirb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sel_addr_n,
    input  logic              sel_data_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic              byte_done,
    output logic              byte_is_addr,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [2:0] sclk_sy, sa_sy, sd_sy;
    logic [1:0] mosi_sy;
    logic              frame_q, is_addr_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] rx_sr_q, tx_sr_q;

    wire frame_now = !sa_sy[1] || !sd_sy[1];
    wire rise      = sclk_sy[1] && !sclk_sy[2];
    wire fall      = !sclk_sy[1] && sclk_sy[2];
    wire start     = frame_now && !frame_q;

    // Synchronise the SPI inputs into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0; sa_sy <= '1; sd_sy <= '1; mosi_sy <= '0;
        end else begin
            sclk_sy <= {sclk_sy[1:0], sclk};
            sa_sy   <= {sa_sy[1:0], sel_addr_n};
            sd_sy   <= {sd_sy[1:0], sel_data_n};
            mosi_sy <= {mosi_sy[0], mosi};
        end
    end

    // Track the frame, shift bits in on rising edges and out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0; is_addr_q <= 1'b0; bitcnt_q <= '0;
            rx_sr_q <= '0; tx_sr_q <= '0; byte_done <= 1'b0; rx_byte <= '0;
        end else begin
            frame_q   <= frame_now;
            byte_done <= 1'b0;
            if (start) begin
                is_addr_q <= !sa_sy[1];
                bitcnt_q  <= '0;
                tx_sr_q   <= !sa_sy[1] ? '0 : tx_byte;
            end else if (!frame_now) begin
                bitcnt_q <= '0;
            end else if (rise) begin
                rx_sr_q  <= {rx_sr_q[BYTE_W-2:0], mosi_sy[1]};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == CNT_W'(BYTE_W-1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr_q[BYTE_W-2:0], mosi_sy[1]};
                end
            end else if (fall) begin
                if (bitcnt_q == '0) tx_sr_q <= is_addr_q ? '0 : tx_byte;
                else                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso         = tx_sr_q[BYTE_W-1];
    assign byte_is_addr = is_addr_q;

    // R1: nothing but zeros leaves during an address frame
    assert_addr_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q && is_addr_q && $past(frame_q)) |-> !miso);
    // R11: a byte can only complete inside an open frame
    assert_done_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(frame_q));
endmodule

// File: rtl/spirb_ctrl.sv
// Address/data phase controller: latches the address byte, pairs data bytes
// into words and raises one-cycle backend strobes after the second byte.
// Assumes byte_done pulses come from spirb_shifter.
module spirb_ctrl
    import spirb_pkg::*;
#(
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [WORD_W-1:0] rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] be_addr,
    output logic [WORD_W-1:0] be_wdata,
    output logic              be_wen,
    output logic              be_ren
);
    logic              rd_q, hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Latch the address phase, pair data bytes and issue strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_addr <= '0; rd_q <= 1'b0; hi_q <= 1'b0; lo_q <= '0;
            be_wdata <= '0; be_wen <= 1'b0; be_ren <= 1'b0;
        end else begin
            be_wen <= 1'b0;
            be_ren <= 1'b0;
            if (byte_done && byte_is_addr) begin
                rd_q    <= rx_byte[BYTE_W-1];
                be_addr <= rx_byte[ADDR_W-1:0];
                hi_q    <= 1'b0;
            end else if (byte_done) begin
                hi_q <= !hi_q;
                if (!hi_q) begin
                    lo_q <= rx_byte;
                end else begin
                    be_wdata <= LSB_FIRST ? {rx_byte, lo_q} : {lo_q, rx_byte};
                    be_wen   <= !rd_q;
                    be_ren   <= rd_q;
                end
            end
        end
    end

    // Choose the half of the read word that goes out next.
    always_comb begin
        if (!rd_q)                  tx_byte = '0;
        else if (hi_q == LSB_FIRST) tx_byte = rdata[WORD_W-1:BYTE_W];
        else                        tx_byte = rdata[BYTE_W-1:0];
    end

    // R2: a word needs two bytes, so strobes never repeat on adjacent cycles
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (be_wen || be_ren) |=> !(be_wen || be_ren));
    // R2: read and write strobes are exclusive
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_wen && be_ren));
endmodule

// File: rtl/spirb_fifo.sv
// Show-ahead FIFO: head always presents the oldest entry.
// Pushes when full and pops when empty are dropped. Assumes push and pop never coincide.
module spirb_fifo
    import spirb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] head,
    output logic [AW:0]       level
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;

    wire do_push = push && (level != (AW+1)'(DEPTH));
    wire do_pop  = pop && (level != '0);

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= din;
    end

    // Advance pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0; rptr_q <= '0; level <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    assign head = mem[rptr_q];

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == (AW+1)'(DEPTH) && push && !pop) |=> level == (AW+1)'(DEPTH));
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop && !push) |=> level == '0);
endmodule

// File: rtl/spirb_regs.sv
// Register map behind the backend strobes: operands, registered sum, FIFO port,
// RAM address/data ports and the enable bit. Reads are combinational, writes registered.
module spirb_regs
    import spirb_pkg::*;
#(
    parameter int FIFO_AW = 8,
    parameter int RAM_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wen,
    input  logic              ren,
    output logic [WORD_W-1:0] rdata
);
    localparam int RAM_DEPTH = 1 << RAM_AW;

    logic [WORD_W-1:0] opa_q, opb_q, opc_q, sum_q;
    logic              en_q;
    logic [RAM_AW-1:0] ram_wa_q, ram_ra_q;
    logic [WORD_W-1:0] ram [RAM_DEPTH];
    logic [WORD_W-1:0] fifo_head;
    logic [FIFO_AW:0]  fifo_level;

    wire fifo_push = en_q && wen && (addr == RG_FIFO);
    wire fifo_pop  = en_q && ren && (addr == RG_FIFO);

    spirb_fifo #(.AW(FIFO_AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
        .din(wdata), .head(fifo_head), .level(fifo_level)
    );

    // Registered writes to the plain registers and the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0; opb_q <= '0; opc_q <= '0; sum_q <= '0; en_q <= 1'b0;
            ram_wa_q <= '0; ram_ra_q <= '0;
        end else begin
            if (en_q) sum_q <= opa_q + opb_q + opc_q;
            if (wen) begin
                case (addr)
                    RG_OPA:   opa_q    <= wdata;
                    RG_OPB:   opb_q    <= wdata;
                    RG_OPC:   opc_q    <= wdata;
                    RG_RWADR: ram_wa_q <= wdata[RAM_AW-1:0];
                    RG_RRADR: ram_ra_q <= wdata[RAM_AW-1:0];
                    RG_CTRL:  en_q     <= wdata[0];
                    default:  ;
                endcase
            end
        end
    end

    // RAM store through the data port, gated by the enable.
    always_ff @(posedge clk) begin
        if (en_q && wen && addr == RG_RDATA) ram[ram_wa_q] <= wdata;
    end

    // Combinational read mux.
    always_comb begin
        case (addr)
            RG_SUM:   rdata = sum_q;
            RG_OPA:   rdata = opa_q;
            RG_OPB:   rdata = opb_q;
            RG_OPC:   rdata = opc_q;
            RG_FIFO:  rdata = (en_q && fifo_level != '0) ? fifo_head : '0;
            RG_RDATA: rdata = en_q ? ram[ram_ra_q] : '0;
            RG_CTRL:  rdata = {{(WORD_W-1){1'b0}}, en_q};
            default:  rdata = '0;
        endcase
    end

    // R4: disabled summation holds its value
    assert_sum_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(sum_q));
    // R9: FIFO accesses while disabled leave the fill level alone
    assert_fifo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && (wen || ren) && addr == RG_FIFO) |=> $stable(fifo_level));
endmodule

// File: rtl/spi_regbridge.sv
// Top of the address/data SPI register bridge: SPI byte shifter, phase
// controller and register map. Assumes SCLK half-period >= 5 clk cycles.
module spi_regbridge
    import spirb_pkg::*;
#(
    parameter int FIFO_AW   = 8,
    parameter int RAM_AW    = 8,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_sel_addr_n,
    input  logic spi_sel_data_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic              byte_done, byte_is_addr, be_wen, be_ren;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] be_addr;
    logic [WORD_W-1:0] be_wdata, be_rdata;

    spirb_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .sel_addr_n(spi_sel_addr_n),
        .sel_data_n(spi_sel_data_n), .mosi(spi_mosi), .tx_byte(tx_byte),
        .miso(spi_miso), .byte_done(byte_done), .byte_is_addr(byte_is_addr),
        .rx_byte(rx_byte)
    );

    spirb_ctrl #(.LSB_FIRST(LSB_FIRST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_is_addr(byte_is_addr),
        .rx_byte(rx_byte), .rdata(be_rdata), .tx_byte(tx_byte), .be_addr(be_addr),
        .be_wdata(be_wdata), .be_wen(be_wen), .be_ren(be_ren)
    );

    spirb_regs #(.FIFO_AW(FIFO_AW), .RAM_AW(RAM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(be_addr), .wdata(be_wdata),
        .wen(be_wen), .ren(be_ren), .rdata(be_rdata)
    );
endmodule

// File: tb/spi_regbridge_tb.sv
module spi_regbridge_tb;
    localparam int CLK_P = 10;
    localparam int HALF  = 5;
    localparam int GAP   = 6;
    localparam int FAW   = 3;
    localparam int FDEP  = 1 << FAW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sa_n = 1'b1, sd_n = 1'b1, mosi = 1'b0;
    logic miso;
    int   total = 0, fails = 0, cyc = 0;
    bit   done = 1'b0;
    logic [15:0] wbuf [16];
    logic [15:0] rbuf [16];
    logic [15:0] v, s_old;
    logic [15:0] op [3];

    always #(CLK_P/2) clk = ~clk;

    spi_regbridge #(.FIFO_AW(FAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sel_addr_n(sa_n),
        .spi_sel_data_n(sd_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            total = total + 1; fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<190000 cycles", cyc);
            report();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send_addr(input logic rd, input logic [6:0] a);
        logic [7:0] junk;
        sa_n = 1'b0;
        shift_byte({rd, a}, junk);
        tick(HALF);
        sa_n = 1'b1;
        tick(GAP);
    endtask

    // One data frame of n words, low byte first.
    task automatic data_frame(input int n);
        logic [7:0] lo, hi;
        sd_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            shift_byte(wbuf[k][7:0], lo);
            shift_byte(wbuf[k][15:8], hi);
            rbuf[k] = {hi, lo};
        end
        tick(HALF);
        sd_n = 1'b1;
        tick(GAP);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [15:0] d);
        send_addr(1'b0, a);
        wbuf[0] = d;
        data_frame(1);
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [15:0] d);
        send_addr(1'b1, a);
        wbuf[0] = '0;
        data_frame(1);
        d = rbuf[0];
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // Reset state
        rd_reg(7'd1, v); chk("R3 reset opa", v, 16'h0000);
        rd_reg(7'd0, v); chk("R4 reset sum", v, 16'h0000);
        rd_reg(7'd8, v); chk("R8 reset ctrl", v, 16'h0000);

        // Enable: only bit 0 is kept
        wr_reg(7'd8, 16'hFFFF);
        rd_reg(7'd8, v); chk("R8 ctrl readback", v, 16'h0001);

        // Operand sweep with sum, including wrap-around
        for (int p = 0; p < 6; p++) begin
            op[0] = (p == 5) ? 16'hFFFF : 16'(16'h1357 * (p + 1));
            op[1] = (p == 5) ? 16'hFFFF : 16'(16'h0A0B ^ (p * 16'h1111));
            op[2] = (p == 5) ? 16'h0003 : 16'(16'hF00D + p * 16'h0101);
            for (int r = 0; r < 3; r++) wr_reg(7'(r + 1), op[r]);
            for (int r = 0; r < 3; r++) begin
                rd_reg(7'(r + 1), v); chk("R3 operand readback", v, op[r]);
            end
            rd_reg(7'd0, v); chk("R4 sum", v, 16'(op[0] + op[1] + op[2]));
        end

        // Byte order: first byte is the low half
        wr_reg(7'd1, 16'h12AB); wr_reg(7'd2, 16'h0001); wr_reg(7'd3, 16'h0000);
        rd_reg(7'd0, v); chk("R2 low byte first via sum", v, 16'h12AC);
        rd_reg(7'd1, v); chk("R11 miso bytes of 12AB", v, 16'h12AB);

        // Address held across data frames
        send_addr(1'b1, 7'd2);
        wbuf[0] = '0; data_frame(1); chk("R1 held read 1", rbuf[0], 16'h0001);
        data_frame(1);               chk("R1 held read 2", rbuf[0], 16'h0001);
        send_addr(1'b0, 7'd3);
        wbuf[0] = 16'h00C4; data_frame(1);
        wbuf[0] = 16'h00C5; data_frame(1);
        rd_reg(7'd3, v); chk("R1 held write last wins", v, 16'h00C5);

        // Read-only and unmapped addresses
        rd_reg(7'd0, s_old);
        wr_reg(7'd0, 16'h5555);
        rd_reg(7'd0, v); chk("R10 sum write ignored", v, s_old);
        wr_reg(7'd9, 16'h7777); wr_reg(7'd127, 16'h7777);
        rd_reg(7'd9, v);   chk("R10 unmapped 9 reads 0", v, 16'h0000);
        rd_reg(7'd127, v); chk("R10 unmapped 127 reads 0", v, 16'h0000);
        rd_reg(7'd5, v);   chk("R10 waddr reads 0", v, 16'h0000);
        rd_reg(7'd1, v);   chk("R10 opa untouched", v, 16'h12AB);

        // FIFO streaming after one address byte
        for (int k = 0; k < 5; k++) wbuf[k] = 16'(16'hA100 + k * 16'h0203);
        send_addr(1'b0, 7'd4); data_frame(5);
        for (int k = 0; k < 5; k++) wbuf[k] = '0;
        send_addr(1'b1, 7'd4); data_frame(3);
        for (int k = 0; k < 3; k++) chk("R5 fifo order frame 1", rbuf[k], 16'(16'hA100 + k * 16'h0203));
        data_frame(2);
        for (int k = 0; k < 2; k++) chk("R5 fifo order frame 2", rbuf[k], 16'(16'hA100 + (k + 3) * 16'h0203));

        // FIFO overflow and underflow
        for (int k = 0; k < FDEP + 2; k++) wbuf[k] = 16'(16'h3C00 + k * 16'h0111);
        send_addr(1'b0, 7'd4); data_frame(FDEP + 2);
        for (int k = 0; k < FDEP + 1; k++) wbuf[k] = '0;
        send_addr(1'b1, 7'd4); data_frame(FDEP + 1);
        for (int k = 0; k < FDEP; k++) chk("R6 fifo fill", rbuf[k], 16'(16'h3C00 + k * 16'h0111));
        chk("R6 empty read 0", rbuf[FDEP], 16'h0000);

        // RAM sweep across the address space
        for (int i = 0; i < 16; i++) begin
            wr_reg(7'd5, 16'(i * 17));
            wr_reg(7'd7, 16'((i * 17) * 16'h0101 ^ 16'h5A3C));
        end
        for (int i = 15; i >= 0; i--) begin
            wr_reg(7'd6, 16'(i * 17));
            rd_reg(7'd7, v); chk("R7 ram readback", v, 16'((i * 17) * 16'h0101 ^ 16'h5A3C));
        end

        // Disabled behaviour
        wr_reg(7'd8, 16'h0000);
        rd_reg(7'd0, s_old);
        wr_reg(7'd1, 16'h0100);
        rd_reg(7'd0, v); chk("R4 sum holds when disabled", v, s_old);
        wr_reg(7'd4, 16'hBEEF);
        rd_reg(7'd4, v); chk("R9 fifo read 0 when disabled", v, 16'h0000);
        wr_reg(7'd5, 16'd34); wr_reg(7'd7, 16'hDEAD); wr_reg(7'd6, 16'd34);
        rd_reg(7'd7, v); chk("R9 ram read 0 when disabled", v, 16'h0000);
        wr_reg(7'd8, 16'h0001);
        rd_reg(7'd7, v); chk("R9 ram store ignored", v, 16'((34) * 16'h0101 ^ 16'h5A3C));
        rd_reg(7'd4, v); chk("R9 fifo push ignored", v, 16'h0000);
        rd_reg(7'd0, v); chk("R4 sum resumes", v, 16'(16'h0100 + 16'h0001 + 16'h00C5));

        report();
    end
endmodule